// File: doc/BRIEF.md
# Dual Timer/Counter with Shared Prescaler

This block holds two general-purpose up-counters: a narrow one (8 bits by default) and a wide one (16 bits by default). A single free-running prescaler, 10 bits wide, runs from reset and is shared by both counters. Each counter has its own 3-bit clock-select field. The field either stops the counter or picks one of five prescaler taps (divide by 1, 8, 64, 256 or 1024). It can also make the counter count edges on its own external pin, after those edges pass through a two-flop synchronizer.

Software uses one write port with a 3-bit address. Through it, software loads the clock-select fields, loads either count value, and clears the sticky overflow flags. Both count values and both overflow flags are visible on output ports at all times.

Top module: `dual_tc_unit`

## Requirements
- R1: Reset sets both counts to zero, both overflow flags to zero and both clock-select fields to 000. While nothing is written afterwards, neither count moves.
- R2: A write to address 0 loads the narrow counter's select field from `wr_data[2:0]`, and a write to address 1 loads the wide counter's field. Select value 000 holds the count.
- R3: Select value 001 advances the count by one on every clock cycle, starting in the cycle after the select write.
- R4: Select values 010, 011, 100 and 101 advance the count once every 8, 64, 256 and 1024 cycles. Any window of a multiple of that many cycles therefore holds exactly that multiple's share of increments.
- R5: Both counters take their taps from one shared prescaler. When both select the same divide value, they advance in the same cycles.
- R6: Select value 111 advances the count by exactly one for each rising edge of the counter's external pin. Falling edges have no effect.
- R7: Select value 110 advances the count by exactly one for each falling edge of the counter's external pin. Rising edges have no effect.
- R8: An edge on the external pin changes the count at the third rising clock edge after the pin changes, and not earlier.
- R9: When the narrow counter wraps from all ones to zero, its overflow flag goes to 1 and stays at 1 until it is cleared.
- R10: A write to address 4 clears the narrow flag where `wr_data[0]` is 1 and the wide flag where `wr_data[1]` is 1. Zero bits leave the flags unchanged.
- R11: A write to address 2 (narrow) or address 3 (wide) loads the count from `wr_data`. A load takes priority over an increment in the same cycle.
- R12: The wide counter wraps from all ones to zero and sets its own overflow flag. The narrow flag is left unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_pin_a | input | 1 | External count input for the narrow counter |
| ext_pin_b | input | 1 | External count input for the wide counter |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Write address: 0/1 select fields, 2/3 counts, 4 flag clear |
| wr_data | input | CNT_B_W | Write data |
| cnt_a | output | CNT_A_W | Narrow counter value |
| cnt_b | output | CNT_B_W | Wide counter value |
| ovf_a | output | 1 | Narrow counter overflow flag |
| ovf_b | output | 1 | Wide counter overflow flag |

## Verification
The hardest case to reach from the ports is a proof that the two counters really share one prescaler phase and do not each keep a private divider. The bench sets both counters to divide by 256 in back-to-back writes. It then compares their increments at every cycle over two full prescaler periods, so a tap that fired in a different cycle for one counter would be caught at once.

The slow taps are checked over windows whose length is a whole multiple of the divide value. This makes the expected increment count independent of the prescaler phase at the moment the select write lands. The timing of the external pin is checked cycle by cycle across the synchronizer.

// File: rtl/tc_pkg.sv
package tc_pkg;

  // Clock-select codes; the numeric order is decoded by the counter.
  typedef enum logic [2:0] {
    CS_STOP     = 3'b000,
    CS_DIV1     = 3'b001,
    CS_DIV8     = 3'b010,
    CS_DIV64    = 3'b011,
    CS_DIV256   = 3'b100,
    CS_DIV1024  = 3'b101,
    CS_EXT_FALL = 3'b110,
    CS_EXT_RISE = 3'b111
  } cs_e;

  // Number of prescaler tap outputs (divide by 1 included).
  localparam int NUM_TAPS = 5;

  // Low prescaler bits that must be all ones for taps 1..4.
  localparam int TAP_BITS [4] = '{3, 6, 8, 10};

  // Write address map.
  localparam logic [2:0] ADDR_SEL_A = 3'd0;
  localparam logic [2:0] ADDR_SEL_B = 3'd1;
  localparam logic [2:0] ADDR_CNT_A = 3'd2;
  localparam logic [2:0] ADDR_CNT_B = 3'd3;
  localparam logic [2:0] ADDR_CLR   = 3'd4;

endpackage

// File: rtl/tc_prescaler.sv
module tc_prescaler
  import tc_pkg::*;
#(
  parameter int PSC_W = 10
) (
  input  logic                clk,
  input  logic                rst_n,
  output logic [NUM_TAPS-1:0] tap_o
);

  logic [PSC_W-1:0] psc_q;
  logic [PSC_W-1:0] psc_d;

  always_comb begin
    psc_d = psc_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      psc_q <= '0;
    end else begin
      psc_q <= psc_d;
    end
  end

  assign tap_o[0] = 1'b1;

  for (genvar gi = 0; gi < NUM_TAPS - 1; gi++) begin : g_tap
    assign tap_o[gi+1] = &psc_q[TAP_BITS[gi]-1:0];
  end

endmodule

// File: rtl/tc_edge_sync.sv
module tc_edge_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_i,
  output logic rise_o,
  output logic fall_o
);

  localparam int DEPTH = SYNC_STAGES + 1;

  logic [DEPTH-1:0] shf_q;
  logic [DEPTH-1:0] shf_d;

  always_comb begin
    shf_d = {shf_q[DEPTH-2:0], pin_i};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shf_q <= '0;
    end else begin
      shf_q <= shf_d;
    end
  end

  assign rise_o =  shf_q[DEPTH-2] & ~shf_q[DEPTH-1];
  assign fall_o = ~shf_q[DEPTH-2] &  shf_q[DEPTH-1];

endmodule

// File: rtl/tc_counter.sv
module tc_counter
  import tc_pkg::*;
#(
  parameter int W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  cs_e                 sel_i,
  input  logic [NUM_TAPS-1:0] tap_i,
  input  logic                ext_rise_i,
  input  logic                ext_fall_i,
  input  logic                load_i,
  input  logic [W-1:0]        load_val_i,
  input  logic                clr_ovf_i,
  output logic [W-1:0]        cnt_o,
  output logic                ovf_o
);

  logic [W-1:0] cnt_q, cnt_d;
  logic         cnt_en;
  logic         ovf_q, ovf_d;
  logic         tick;
  logic         inc_en;
  logic         wrap;

  always_comb begin
    unique case (sel_i)
      CS_STOP:     tick = 1'b0;
      CS_DIV1:     tick = tap_i[0];
      CS_DIV8:     tick = tap_i[1];
      CS_DIV64:    tick = tap_i[2];
      CS_DIV256:   tick = tap_i[3];
      CS_DIV1024:  tick = tap_i[4];
      CS_EXT_FALL: tick = ext_fall_i;
      CS_EXT_RISE: tick = ext_rise_i;
      default:     tick = 1'b0;
    endcase
  end

  always_comb begin
    inc_en = tick & ~load_i;
    wrap   = inc_en & (&cnt_q);
    cnt_en = load_i | inc_en;
    cnt_d  = load_i ? load_val_i : cnt_q + 1'b1;
    if (wrap) begin
      ovf_d = 1'b1;
    end else if (clr_ovf_i) begin
      ovf_d = 1'b0;
    end else begin
      ovf_d = ovf_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ovf_q <= 1'b0;
    end else begin
      ovf_q <= ovf_d;
    end
  end

  assign cnt_o = cnt_q;
  assign ovf_o = ovf_q;

endmodule

// File: rtl/dual_tc_unit.sv
module dual_tc_unit
  import tc_pkg::*;
#(
  parameter int CNT_A_W     = 8,
  parameter int CNT_B_W     = 16,
  parameter int PSC_W       = 10,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ext_pin_a,
  input  logic               ext_pin_b,
  input  logic               wr_en,
  input  logic [2:0]         wr_addr,
  input  logic [CNT_B_W-1:0] wr_data,
  output logic [CNT_A_W-1:0] cnt_a,
  output logic [CNT_B_W-1:0] cnt_b,
  output logic               ovf_a,
  output logic               ovf_b
);

  localparam int NUM_CH = 2;

  logic [NUM_TAPS-1:0] taps;
  logic [NUM_CH-1:0]   ext_pins;
  logic [NUM_CH-1:0]   ext_rise;
  logic [NUM_CH-1:0]   ext_fall;

  cs_e  sel_a_q, sel_a_d;
  cs_e  sel_b_q, sel_b_d;
  logic sel_a_en, sel_b_en;
  logic load_a, load_b;
  logic clr_a, clr_b;

  // Write decode
  always_comb begin
    sel_a_en = wr_en && (wr_addr == ADDR_SEL_A);
    sel_b_en = wr_en && (wr_addr == ADDR_SEL_B);
    load_a   = wr_en && (wr_addr == ADDR_CNT_A);
    load_b   = wr_en && (wr_addr == ADDR_CNT_B);
    clr_a    = wr_en && (wr_addr == ADDR_CLR) && wr_data[0];
    clr_b    = wr_en && (wr_addr == ADDR_CLR) && wr_data[1];
    sel_a_d  = cs_e'(wr_data[2:0]);
    sel_b_d  = cs_e'(wr_data[2:0]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_a_q <= CS_STOP;
    end else if (sel_a_en) begin
      sel_a_q <= sel_a_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_b_q <= CS_STOP;
    end else if (sel_b_en) begin
      sel_b_q <= sel_b_d;
    end
  end

  tc_prescaler #(.PSC_W(PSC_W)) u_psc (
    .clk   (clk),
    .rst_n (rst_n),
    .tap_o (taps)
  );

  assign ext_pins = {ext_pin_b, ext_pin_a};

  for (genvar gc = 0; gc < NUM_CH; gc++) begin : g_sync
    tc_edge_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
      .clk    (clk),
      .rst_n  (rst_n),
      .pin_i  (ext_pins[gc]),
      .rise_o (ext_rise[gc]),
      .fall_o (ext_fall[gc])
    );
  end

  tc_counter #(.W(CNT_A_W)) u_cnt_a (
    .clk        (clk),
    .rst_n      (rst_n),
    .sel_i      (sel_a_q),
    .tap_i      (taps),
    .ext_rise_i (ext_rise[0]),
    .ext_fall_i (ext_fall[0]),
    .load_i     (load_a),
    .load_val_i (wr_data[CNT_A_W-1:0]),
    .clr_ovf_i  (clr_a),
    .cnt_o      (cnt_a),
    .ovf_o      (ovf_a)
  );

  tc_counter #(.W(CNT_B_W)) u_cnt_b (
    .clk        (clk),
    .rst_n      (rst_n),
    .sel_i      (sel_b_q),
    .tap_i      (taps),
    .ext_rise_i (ext_rise[1]),
    .ext_fall_i (ext_fall[1]),
    .load_i     (load_b),
    .load_val_i (wr_data),
    .clr_ovf_i  (clr_b),
    .cnt_o      (cnt_b),
    .ovf_o      (ovf_b)
  );

endmodule

// File: rtl/tc_checker.sv
module tc_checker #(
  parameter int WA = 8,
  parameter int WB = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          wr_en,
  input logic [2:0]    wr_addr,
  input logic [WB-1:0] wr_data,
  input logic [2:0]    sel_a,
  input logic [WA-1:0] cnt_a,
  input logic [WB-1:0] cnt_b,
  input logic          ovf_a,
  input logic          ovf_b
);

  logic ld_a, ld_b, clr_a, clr_b;
  assign ld_a  = wr_en && (wr_addr == 3'd2);
  assign ld_b  = wr_en && (wr_addr == 3'd3);
  assign clr_a = wr_en && (wr_addr == 3'd4) && wr_data[0];
  assign clr_b = wr_en && (wr_addr == 3'd4) && wr_data[1];

  // R2: a stopped counter holds its value
  p_stop_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_a == 3'b000 && !ld_a) |=> $stable(cnt_a));

  // R3: divide-by-1 steps every cycle
  p_div1_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_a == 3'b001 && !ld_a) |=> cnt_a == WA'($past(cnt_a) + 1'b1));

  // R11: a load wins over an increment
  p_load_wins_r11: assert property (@(posedge clk) disable iff (!rst_n)
    ld_a |=> cnt_a == $past(wr_data[WA-1:0]));

  // R9: the narrow flag rises only on a wrap to zero
  p_ovf_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovf_a) |-> (cnt_a == '0 && $past(cnt_a) == '1));

  // R9: the narrow flag is sticky
  p_ovf_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_a && !clr_a) |=> ovf_a);

  // R12: the wide flag is sticky
  p_ovf_sticky_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_b && !clr_b) |=> ovf_b);

  // R6: without a load the wide count moves by at most one
  p_step_one_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !ld_b |=> (cnt_b == $past(cnt_b) || cnt_b == WB'($past(cnt_b) + 1'b1)));

endmodule

bind dual_tc_unit tc_checker #(.WA(CNT_A_W), .WB(CNT_B_W)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .wr_en   (wr_en),
  .wr_addr (wr_addr),
  .wr_data (wr_data),
  .sel_a   (sel_a_q),
  .cnt_a   (cnt_a),
  .cnt_b   (cnt_b),
  .ovf_a   (ovf_a),
  .ovf_b   (ovf_b)
);

// File: tb/test_dual_tc_unit.sv
module test_dual_tc_unit;

  logic        clk;
  logic        rst_n;
  logic        ext_pin_a, ext_pin_b;
  logic        wr_en;
  logic [2:0]  wr_addr;
  logic [15:0] wr_data;
  logic [7:0]  cnt_a;
  logic [15:0] cnt_b;
  logic        ovf_a, ovf_b;

  int checks = 0;
  int errors = 0;

  dual_tc_unit i_dual_tc_unit (
    .clk       (clk),
    .rst_n     (rst_n),
    .ext_pin_a (ext_pin_a),
    .ext_pin_b (ext_pin_b),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .cnt_a     (cnt_a),
    .cnt_b     (cnt_b),
    .ovf_a     (ovf_a),
    .ovf_b     (ovf_b)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset;
    chk("R1 cnt_a", {24'd0, cnt_a}, 0);
    chk("R1 cnt_b", {16'd0, cnt_b}, 0);
    chk("R1 ovf", {30'd0, ovf_b, ovf_a}, 0);
    wait_n(20);
    chk("R1 stopped a", {24'd0, cnt_a}, 0);
    chk("R1 stopped b", {16'd0, cnt_b}, 0);
  endtask

  task automatic t_div1_stop;
    logic [7:0] a0;
    wr(3'd0, 16'd1);
    a0 = cnt_a;
    wait_n(10);
    chk("R3 div1", {24'd0, cnt_a}, {24'd0, 8'(a0 + 8'd10)});
    wr(3'd0, 16'd0);
    a0 = cnt_a;
    wait_n(15);
    chk("R2 stop holds", {24'd0, cnt_a}, {24'd0, a0});
  endtask

  task automatic t_prescale;
    logic [15:0] b0;
    int divs [4] = '{8, 64, 256, 1024};
    for (int k = 0; k < 4; k++) begin
      wr(3'd1, 16'(k + 2));
      b0 = cnt_b;
      wait_n(divs[k] * 4);
      chk($sformatf("R4 div%0d", divs[k]), {16'd0, 16'(cnt_b - b0)}, 32'd4);
    end
    wr(3'd1, 16'd0);
  endtask

  task automatic t_shared;
    logic [7:0]  a0;
    logic [15:0] b0;
    int mism = 0;
    wr(3'd0, 16'd4);
    wr(3'd1, 16'd4);
    a0 = cnt_a; b0 = cnt_b;
    for (int i = 0; i < 2048; i++) begin
      @(negedge clk);
      if (16'(cnt_a - a0) != 16'(cnt_b - b0)) mism++;
    end
    chk("R5 same-cycle steps", mism, 0);
    chk("R5 delta", {16'd0, 16'(cnt_b - b0)}, 32'd8);
    wr(3'd0, 16'd0);
    wr(3'd1, 16'd0);
  endtask

  task automatic t_ext_rise;
    logic [7:0] a0;
    wr(3'd0, 16'd7);
    a0 = cnt_a;
    ext_pin_a = 1'b1;
    @(negedge clk);
    chk("R8 no change after 1 edge", {24'd0, cnt_a}, {24'd0, a0});
    @(negedge clk);
    chk("R8 no change after 2 edges", {24'd0, cnt_a}, {24'd0, a0});
    @(negedge clk);
    chk("R8 step at third edge", {24'd0, cnt_a}, {24'd0, 8'(a0 + 1)});
    ext_pin_a = 1'b0;
    wait_n(6);
    chk("R6 falling ignored", {24'd0, cnt_a}, {24'd0, 8'(a0 + 1)});
    for (int i = 0; i < 5; i++) begin
      ext_pin_a = 1'b1; wait_n(4);
      ext_pin_a = 1'b0; wait_n(4);
    end
    chk("R6 five rising", {24'd0, cnt_a}, {24'd0, 8'(a0 + 6)});
    wr(3'd0, 16'd0);
  endtask

  task automatic t_ext_fall;
    logic [15:0] b0;
    wr(3'd1, 16'd6);
    b0 = cnt_b;
    ext_pin_b = 1'b1;
    ext_pin_a = 1'b1;
    wait_n(6);
    chk("R7 rising ignored", {16'd0, cnt_b}, {16'd0, b0});
    ext_pin_b = 1'b0;
    wait_n(6);
    chk("R7 falling counts", {16'd0, cnt_b}, {16'd0, 16'(b0 + 1)});
    ext_pin_a = 1'b0;
    wait_n(6);
    chk("R7 other pin ignored", {16'd0, cnt_b}, {16'd0, 16'(b0 + 1)});
    wr(3'd1, 16'd0);
  endtask

  task automatic t_load_prio;
    wr(3'd0, 16'd1);
    wr(3'd2, 16'h0040);
    chk("R11 load wins", {24'd0, cnt_a}, 32'h40);
    @(negedge clk);
    chk("R11 resumes", {24'd0, cnt_a}, 32'h41);
  endtask

  task automatic t_ovf_a;
    wr(3'd2, 16'h00FD);
    @(negedge clk);
    @(negedge clk);
    chk("R9 no flag before wrap", {31'd0, ovf_a}, 0);
    @(negedge clk);
    chk("R9 wrapped", {24'd0, cnt_a}, 0);
    chk("R9 flag set", {31'd0, ovf_a}, 1);
    wr(3'd0, 16'd0);
    wait_n(10);
    chk("R9 flag sticky", {31'd0, ovf_a}, 1);
    wr(3'd4, 16'h0002);
    chk("R10 other bit no clear", {31'd0, ovf_a}, 1);
    wr(3'd4, 16'h0000);
    chk("R10 zero no clear", {31'd0, ovf_a}, 1);
    wr(3'd4, 16'h0001);
    chk("R10 clear", {31'd0, ovf_a}, 0);
  endtask

  task automatic t_ovf_b;
    wr(3'd1, 16'd1);
    wr(3'd3, 16'hFFFE);
    chk("R11 wide load", {16'd0, cnt_b}, 32'hFFFE);
    @(negedge clk);
    chk("R12 no flag yet", {31'd0, ovf_b}, 0);
    @(negedge clk);
    chk("R12 wrapped", {16'd0, cnt_b}, 0);
    chk("R12 flag set", {31'd0, ovf_b}, 1);
    chk("R12 narrow flag untouched", {31'd0, ovf_a}, 0);
    wr(3'd1, 16'd0);
    wr(3'd4, 16'h0002);
    chk("R10 wide clear", {31'd0, ovf_b}, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    ext_pin_a = 1'b0; ext_pin_b = 1'b0;
    wr_en = 1'b0; wr_addr = 3'd0; wr_data = 16'd0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_div1_stop();
    t_prescale();
    t_shared();
    t_ext_rise();
    t_ext_fall();
    t_load_prio();
    t_ovf_a();
    t_ovf_b();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule